// File: doc/BRIEF.md
# Byte-Lane ROM Window Decoder

This block sits between an asynchronous 16-bit processor bus and two byte-wide read-only memory banks that together form a 64 KB window. It compares the top address byte against a fixed window base. The comparison only counts while the active-low address strobe is asserted. From the result it produces a chip select, one output enable for each byte bank and a window-hit flag that a separate termination generator can use.

The processor word address is passed straight through to both banks. The bank data is placed on the processor data bus one lane at a time. A lane is driven only on a read inside the window while that lane's data strobe is asserted. At all other times the lane is high-impedance.

A parameter chooses between two enable schemes:

- **Chip-select mode.** The chip select follows the window match, and each output enable follows its data strobe.
- **Always-enabled mode.** This mode suits slow memories. The chip select is held active, and each output enable combines the match, the address strobe, the read direction and the lane strobe.

Top module: `rom_window_dec`

## Requirements
- R1: `win_hit` is 1 exactly when `cpu_as_n` is 0 and `cpu_addr[23:16]` equals 8'hF0.
- R2: While `cpu_as_n` is 1, `win_hit` is 0 and both lanes of `cpu_data` are high-impedance, whatever the address.
- R3: `rom_addr[14:0]` always equals `cpu_addr[15:1]`, so each bank holds 32 KB.
- R4: With SEL_MODE = 0 (chip-select mode), `rom_cs_n` equals the inverse of `win_hit`.
- R5: With SEL_MODE = 0, `rom_hi_oe_n` equals `cpu_uds_n` and `rom_lo_oe_n` equals `cpu_lds_n`.
- R6: With SEL_MODE = 1 (always-enabled mode), `rom_cs_n` is always 0. Each output enable is 0 only when `win_hit` is 1, `cpu_rw` is 1 and the lane's data strobe is 0.
- R7: `cpu_data[15:8]` carries `rom_hi_q` only when `win_hit` is 1, `cpu_rw` is 1 and `cpu_uds_n` is 0; otherwise it is high-impedance. `cpu_data[7:0]` behaves the same way with `rom_lo_q` and `cpu_lds_n`.
- R8: On a write cycle (`cpu_rw` is 0) inside the window, both lanes of `cpu_data` stay high-impedance.
- R9: The addresses 24'hEFFFFE and 24'hF10000 never raise `win_hit` or drive `cpu_data`, even with all strobes asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 23 | Processor word address, bits 23 down to 1 |
| cpu_as_n | input | 1 | Address strobe, active low |
| cpu_uds_n | input | 1 | Upper data strobe (bits 15:8), active low |
| cpu_lds_n | input | 1 | Lower data strobe (bits 7:0), active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_hi_q | input | 8 | Data from the high-byte bank |
| rom_lo_q | input | 8 | Data from the low-byte bank |
| rom_cs_n | output | 1 | Chip select shared by both banks, active low |
| rom_hi_oe_n | output | 1 | High-byte bank output enable, active low |
| rom_lo_oe_n | output | 1 | Low-byte bank output enable, active low |
| rom_addr | output | 15 | Bank address, taken from the processor word address |
| cpu_data | output | 16 | Processor data bus, high-impedance when not driven |
| win_hit | output | 1 | Window match flag for the termination generator |

## Verification
Two instances, one per enable mode, receive the same stimulus. The patterns are:

- **Word reads at several window addresses.** These show that the address is passed through and that both lanes carry the right banks.
- **Single-lane reads.** These separate the upper-lane gating from the lower-lane gating.
- **A window address with the address strobe released.** This shows that the strobe gates the match.
- **A write inside the window.** This shows the difference between the read-only drive and the strobe-only output enables of chip-select mode.
- **The addresses just below and just above the window, and its first and last words.** These pin down the exact bounds of the comparison.

// File: rtl/rom_window_pkg.sv
package rom_window_pkg;
  // enable scheme selector
  typedef enum logic {
    SEL_CHIP   = 1'b0,
    SEL_ALWAYS = 1'b1
  } sel_mode_e;

  localparam int unsigned BUS_W  = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = BUS_W / LANE_W;
endpackage

// File: rtl/rwd_match.sv
module rwd_match #(
  parameter int unsigned       MATCH_W = 8,
  parameter logic [MATCH_W-1:0] BASE   = 8'hF0
) (
  input  logic [MATCH_W-1:0] tag_i,
  input  logic               as_n_i,
  output logic               hit_o
);
  logic [MATCH_W-1:0] bit_eq;

  genvar b;
  generate
    for (b = 0; b < MATCH_W; b++) begin : g_cmp
      assign bit_eq[b] = ~(tag_i[b] ^ BASE[b]);
    end
  endgenerate

  assign hit_o = (&bit_eq) & ~as_n_i;

  always_comb begin
    if (!$isunknown({tag_i, as_n_i})) begin
      // R1
      hit_matches_base_chk: assert (!hit_o || (tag_i == BASE))
        else $error("hit without base match");
    end
  end
endmodule

// File: rtl/rwd_lane.sv
module rwd_lane
  import rom_window_pkg::*;
#(
  parameter sel_mode_e MODE = SEL_CHIP
) (
  input  logic hit_i,
  input  logic as_n_i,
  input  logic ds_n_i,
  input  logic rd_i,
  output logic oe_n_o,
  output logic drive_o
);
  // hit_i already includes the address strobe
  assign drive_o = hit_i & rd_i & ~ds_n_i;

  generate
    if (MODE == SEL_CHIP) begin : g_chip
      assign oe_n_o = ds_n_i;
    end else begin : g_always
      assign oe_n_o = ~(hit_i & ~as_n_i & rd_i & ~ds_n_i);
    end
  endgenerate

  always_comb begin
    if (!$isunknown({hit_i, as_n_i, ds_n_i, rd_i})) begin
      // R8
      no_write_drive_chk: assert (rd_i || !drive_o)
        else $error("lane driven on write");
    end
  end
endmodule

// File: rtl/rwd_bus.sv
module rwd_bus
  import rom_window_pkg::*;
(
  input  logic [LANES-1:0]        drive_i,
  input  logic [LANES*LANE_W-1:0] bank_q_i,
  output logic [BUS_W-1:0]        bus_o
);
  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign bus_o[l*LANE_W +: LANE_W] =
        drive_i[l] ? bank_q_i[l*LANE_W +: LANE_W] : {LANE_W{1'bz}};
    end
  endgenerate
endmodule

// File: rtl/rom_window_dec.sv
module rom_window_dec
  import rom_window_pkg::*;
#(
  parameter int unsigned        MATCH_W  = 8,
  parameter logic [MATCH_W-1:0] WIN_BASE = 8'hF0,
  parameter int unsigned        BANK_AW  = 15,
  parameter sel_mode_e          SEL_MODE = SEL_CHIP
) (
  input  logic [23:1]         cpu_addr,
  input  logic                cpu_as_n,
  input  logic                cpu_uds_n,
  input  logic                cpu_lds_n,
  input  logic                cpu_rw,
  input  logic [7:0]          rom_hi_q,
  input  logic [7:0]          rom_lo_q,
  output logic                rom_cs_n,
  output logic                rom_hi_oe_n,
  output logic                rom_lo_oe_n,
  output logic [BANK_AW-1:0]  rom_addr,
  output logic [15:0]         cpu_data,
  output logic                win_hit
);
  localparam int unsigned TAG_LO = 24 - MATCH_W;

  logic             hit;
  logic [LANES-1:0] lane_ds_n;
  logic [LANES-1:0] lane_oe_n;
  logic [LANES-1:0] lane_drive;

  rwd_match #(.MATCH_W(MATCH_W), .BASE(WIN_BASE)) u_match (
    .tag_i  (cpu_addr[23:TAG_LO]),
    .as_n_i (cpu_as_n),
    .hit_o  (hit)
  );

  // lane 0 = bits 7:0 (lower strobe), lane 1 = bits 15:8 (upper strobe)
  assign lane_ds_n = {cpu_uds_n, cpu_lds_n};

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      rwd_lane #(.MODE(SEL_MODE)) u_lane (
        .hit_i   (hit),
        .as_n_i  (cpu_as_n),
        .ds_n_i  (lane_ds_n[l]),
        .rd_i    (cpu_rw),
        .oe_n_o  (lane_oe_n[l]),
        .drive_o (lane_drive[l])
      );
    end
    if (SEL_MODE == SEL_CHIP) begin : g_cs_chip
      assign rom_cs_n = ~hit;
    end else begin : g_cs_always
      assign rom_cs_n = 1'b0;
    end
  endgenerate

  rwd_bus u_bus (
    .drive_i  (lane_drive),
    .bank_q_i ({rom_hi_q, rom_lo_q}),
    .bus_o    (cpu_data)
  );

  assign rom_addr    = cpu_addr[BANK_AW:1];
  assign rom_hi_oe_n = lane_oe_n[1];
  assign rom_lo_oe_n = lane_oe_n[0];
  assign win_hit     = hit;

  always_comb begin
    if (!$isunknown({cpu_addr, cpu_as_n, cpu_uds_n, cpu_lds_n, cpu_rw})) begin
      // R2
      idle_strobe_chk: assert (!cpu_as_n || (!win_hit && cpu_data === 16'hzzzz))
        else $error("activity with address strobe released");
      // R9
      edge_addr_chk: assert (!({cpu_addr, 1'b0} == 24'hEFFFFE || {cpu_addr, 1'b0} == 24'hF10000) || !win_hit)
        else $error("select outside window");
      // R6
      always_cs_chk: assert (SEL_MODE != SEL_ALWAYS || rom_cs_n == 1'b0)
        else $error("chip select released in always mode");
      // R7
      lane_drive_chk: assert (cpu_uds_n || !cpu_rw || !win_hit || cpu_data[15:8] === rom_hi_q)
        else $error("upper lane not driven on read");
    end
  end
endmodule

// File: tb/rom_window_dec_test.sv
module rom_window_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:1] a;
  logic        as_n, uds_n, lds_n, rw;
  logic [14:0] ra_c, ra_a;
  logic [7:0]  hq_c, lq_c, hq_a, lq_a;
  logic        cs_c, hoe_c, loe_c, hit_c, cs_a, hoe_a, loe_a, hit_a;
  logic [15:0] d_c, d_a;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // behavioural ROM banks
  function automatic logic [7:0] romh(input logic [14:0] x);
    return x[7:0] ^ {x[14:8], 1'b1} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] roml(input logic [14:0] x);
    return x[14:7] + x[7:0] + 8'h33;
  endfunction
  assign hq_c = romh(ra_c); assign lq_c = roml(ra_c);
  assign hq_a = romh(ra_a); assign lq_a = roml(ra_a);

  rom_window_dec #(.SEL_MODE(rom_window_pkg::SEL_CHIP)) uut (
    .cpu_addr(a), .cpu_as_n(as_n), .cpu_uds_n(uds_n), .cpu_lds_n(lds_n), .cpu_rw(rw),
    .rom_hi_q(hq_c), .rom_lo_q(lq_c), .rom_cs_n(cs_c), .rom_hi_oe_n(hoe_c),
    .rom_lo_oe_n(loe_c), .rom_addr(ra_c), .cpu_data(d_c), .win_hit(hit_c));

  rom_window_dec #(.SEL_MODE(rom_window_pkg::SEL_ALWAYS)) uut_alw (
    .cpu_addr(a), .cpu_as_n(as_n), .cpu_uds_n(uds_n), .cpu_lds_n(lds_n), .cpu_rw(rw),
    .rom_hi_q(hq_a), .rom_lo_q(lq_a), .rom_cs_n(cs_a), .rom_hi_oe_n(hoe_a),
    .rom_lo_oe_n(loe_a), .rom_addr(ra_a), .cpu_data(d_a), .win_hit(hit_a));

  typedef struct {
    string       tag;
    logic        hit, cs_c, hoe_c, loe_c, hoe_a, loe_a;
    logic [14:0] ra;
    logic [15:0] d;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [23:0] ad, input logic as, input logic ud,
                       input logic ld, input logic r);
    exp_t e;
    logic rd_hi, rd_lo;
    @(posedge clk);
    a = ad[23:1]; as_n = as; uds_n = ud; lds_n = ld; rw = r;
    e.tag   = tag;
    e.hit   = !as && ad[23:16] == 8'hF0;
    e.ra    = ad[15:1];
    e.cs_c  = !e.hit;
    e.hoe_c = ud;
    e.loe_c = ld;
    rd_hi   = e.hit && r && !ud;
    rd_lo   = e.hit && r && !ld;
    e.hoe_a = !rd_hi;
    e.loe_a = !rd_lo;
    e.d     = {rd_hi ? romh(ad[15:1]) : 8'hzz, rd_lo ? roml(ad[15:1]) : 8'hzz};
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " R1 hit"},       {31'd0, hit_c}, {31'd0, e.hit});
      chk({e.tag, " R1 hit alw"},   {31'd0, hit_a}, {31'd0, e.hit});
      chk({e.tag, " R3 addr"},      {17'd0, ra_c},  {17'd0, e.ra});
      chk({e.tag, " R4 cs"},        {31'd0, cs_c},  {31'd0, e.cs_c});
      chk({e.tag, " R5 oe"},        {30'd0, hoe_c, loe_c}, {30'd0, e.hoe_c, e.loe_c});
      chk({e.tag, " R6 cs alw"},    {31'd0, cs_a},  32'd0);
      chk({e.tag, " R6 oe alw"},    {30'd0, hoe_a, loe_a}, {30'd0, e.hoe_a, e.loe_a});
      chk({e.tag, " R7 data"},      {16'd0, d_c},   {16'd0, e.d});
      chk({e.tag, " R7 data alw"},  {16'd0, d_a},   {16'd0, e.d});
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a = '0; as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw = 1'b1;
    drive("reset idle R2", 24'hF00000, 1, 1, 1, 1);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    drive("word read R1 R7",       24'hF01234, 0, 0, 0, 1);
    drive("word read R3",          24'hF0ABCE, 0, 0, 0, 1);
    drive("upper only R7",         24'hF05556, 0, 0, 1, 1);
    drive("lower only R7",         24'hF07FFE, 0, 1, 0, 1);
    drive("as released R2",        24'hF01234, 1, 0, 0, 1);
    drive("write in window R8",    24'hF04000, 0, 0, 0, 0);
    drive("below window R9",       24'hEFFFFE, 0, 0, 0, 1);
    drive("above window R9",       24'hF10000, 0, 0, 0, 1);
    drive("first word R1",         24'hF00000, 0, 0, 0, 1);
    drive("last word R1 R3",       24'hF0FFFE, 0, 0, 0, 1);
    drive("other region R4",       24'hFC0000, 0, 0, 0, 1);
    drive("strobes idle R5",       24'hF02000, 0, 1, 1, 1);
    drive("back to idle R2",       24'h000000, 1, 1, 1, 1);
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule